// File: doc/BRIEF.md
# I2C Two-Space Memory Target

This block is the bus-facing front end of an I2C target that serves two separate address spaces behind one pair of bus wires: a byte-wide memory array and a clock/control register space. Each space answers to its own 7-bit device code. The block takes SCL and SDA into the system clock domain through two-flop synchronizers. It finds START and STOP conditions and shifts bits in and out. It acknowledges by pulling SDA low through an output-enable, in open-drain fashion. The storage itself sits outside the block. Written bytes leave on a one-cycle strobe. Read bytes come back combinationally on `mem_rdata` for the address and space the block presents.

Behind the device byte come two word-address bytes. These load an address pointer that is shared by both spaces. The pointer starts at zero after reset and steps through the current page, wrapping at the page end. A write transaction that carried at least one data byte is closed by STOP with a commit pulse. The block then stays deaf to the bus for a programmable number of system clocks.

The control path is one state machine. Its states are: `S_IDLE` (wait for START), `S_DEV` (shift in the device byte), `S_DEV_ACK` (acknowledge slot), `S_AHI`/`S_AHI_ACK` (high address byte), `S_ALO`/`S_ALO_ACK` (low address byte), `S_WDAT`/`S_WDAT_ACK` (write data), `S_RDAT` (drive a read byte), `S_RACK` (sample the master's acknowledge) and `S_BUSY` (internal write time).

Its transitions are:
- START moves every state except `S_BUSY` to `S_DEV`.
- STOP moves to `S_BUSY` if data was written, and to `S_IDLE` otherwise.
- A completed byte moves each shift state to its acknowledge state.
- A failed device-byte check moves `S_DEV` to `S_IDLE`.
- The SCL fall that ends an acknowledge slot moves on to the next byte state. From `S_DEV_ACK` the next state is `S_AHI` or `S_RDAT`, chosen by the read/write bit.
- A master NACK in `S_RACK` leads to `S_IDLE`.
- `S_BUSY` returns to `S_IDLE` when its counter runs out.

Top module: `i2c_dual_space_port`

## Requirements
- R1: A device byte whose upper seven bits are 1010111 selects the memory array (`mem_space`=0). A device byte whose upper seven bits are 1101111 selects the control space (`mem_space`=1). Bit 0 of the device byte is the read/write flag (1 = read). Any other code is not acknowledged, and all later bytes are ignored until the next START.
- R2: After a write device byte, the block takes two address bytes, high byte first, and acknowledges each one. Bit 0 of the high byte becomes address bit 8, and the low byte becomes bits 7..0. The other high-byte bits are ignored.
- R3: Each write data byte is acknowledged. Each one also produces a single-cycle `wr_en` with `wr_data`, `mem_addr` and `mem_space` giving the byte and its location.
- R4: After each data byte, the pointer increments within its page. A page is 16 bytes in the array and 8 bytes in the control space, and the pointer wraps from the page's last location to its first.
- R5: After reset, `sda_oe` and `wr_en` are low and the pointer is array location 0. A current-address read (read device byte with no address phase) therefore returns array location 0 first.
- R6: In a random read (address load, repeated START, read device byte), the read device byte is acknowledged only if its code equals the code of the address-loading phase. Otherwise it is not acknowledged.
- R7: A STOP that ends a transaction with at least one written data byte gives exactly one `wr_commit` pulse. A STOP after only address or read traffic gives none.
- R8: For BUSY_CYCLES system clocks after a commit, the block ignores the bus and never pulls SDA low, so a device byte is not acknowledged. After that interval it responds normally.
- R9: Read data goes out MSB first. A master ACK continues with the next location, and a master NACK ends the read with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | High pulls SDA low |
| mem_space | output | 1 | Space of the pointer: 0 array, 1 control |
| mem_addr | output | AW | Address pointer |
| mem_rdata | input | 8 | Read byte for mem_space/mem_addr |
| wr_en | output | 1 | One-cycle write strobe |
| wr_data | output | 8 | Byte to write |
| wr_commit | output | 1 | One-cycle pulse at STOP after written data |

## Verification
The write strobe and the pointer step happen on the same SCL fall. At a page end, the strobe has to carry the last location of the page while the pointer wraps to the first location underneath it. To provoke this, the tests write runs that start two locations below the page end in both spaces, one with address bit 8 set. The captured strobe addresses are then compared with a sequence worked out from the page sizes. A second case comes from the random read, where a repeated START and the device-code check act on an address load that has just finished. This is judged by the acknowledge bit for a matching code and for a foreign code.

// File: rtl/i2c_dsp_pkg.sv
package i2c_dsp_pkg;

    localparam logic [6:0] ARRAY_CODE = 7'b1010111;
    localparam logic [6:0] CTRL_CODE  = 7'b1101111;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_AHI,
        S_AHI_ACK,
        S_ALO,
        S_ALO_ACK,
        S_WDAT,
        S_WDAT_ACK,
        S_RDAT,
        S_RACK,
        S_BUSY
    } dsp_state_t;

endpackage

// File: rtl/i2c_dsp_sync.sv
module i2c_dsp_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_ff;
    logic [SYNC_STAGES-1:0] sda_ff;
    logic                   scl_d;
    logic                   sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
            scl_d  <= scl_ff[SYNC_STAGES-1];
            sda_d  <= sda_ff[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_ff[SYNC_STAGES-1];
    assign sda_s     = sda_ff[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_dsp_ptr.sv
module i2c_dsp_ptr #(
    parameter int AW       = 9,
    parameter int ARR_PAGE = 16,
    parameter int CTL_PAGE = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_space,
    input  logic          space_in,
    input  logic          ld_hi,
    input  logic          ld_lo,
    input  logic          inc,
    input  logic [7:0]    byte_in,
    output logic [AW-1:0] ptr,
    output logic          space
);
    localparam int          ARR_LG   = $clog2(ARR_PAGE);
    localparam int          CTL_LG   = $clog2(CTL_PAGE);
    localparam logic [AW-1:0] ARR_MASK = AW'(ARR_PAGE - 1);
    localparam logic [AW-1:0] CTL_MASK = AW'(CTL_PAGE - 1);

    logic [AW-1:0] page_mask;
    logic [AW-1:0] ptr_step;

    always_comb begin
        page_mask = space ? CTL_MASK : ARR_MASK;
        ptr_step  = (ptr & ~page_mask) | ((ptr + AW'(1)) & page_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr   <= '0;
            space <= 1'b0;
        end else begin
            if (set_space) space <= space_in;
            if (ld_hi)     ptr[AW-1:8] <= byte_in[AW-9:0];
            if (ld_lo)     ptr[7:0] <= byte_in;
            if (inc)       ptr <= ptr_step;
        end
    end

    AST_ARR_WRAP_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !space && !ld_hi && !ld_lo) |=> (ptr[AW-1:ARR_LG] == $past(ptr[AW-1:ARR_LG]))); // R4
    AST_CTL_WRAP_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && space && !ld_hi && !ld_lo) |=> (ptr[AW-1:CTL_LG] == $past(ptr[AW-1:CTL_LG]))); // R4

endmodule

// File: rtl/i2c_dual_space_port.sv
module i2c_dual_space_port
    import i2c_dsp_pkg::*;
#(
    parameter int AW          = 9,
    parameter int ARR_PAGE    = 16,
    parameter int CTL_PAGE    = 8,
    parameter int BUSY_CYCLES = 20000,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    output logic          mem_space,
    output logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_rdata,
    output logic          wr_en,
    output logic [7:0]    wr_data,
    output logic          wr_commit
);
    localparam int BW = $clog2(BUSY_CYCLES + 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    dsp_state_t state, nxt;
    logic [3:0]    bitcnt;
    logic [7:0]    shreg;
    logic          rw_flag, wrote, dummy_pend, dummy_space, m_ack;
    logic [BW-1:0] busy_cnt;

    logic byte_done, code_hit, code_space, dev_ok;
    logic set_space, ld_hi, ld_lo, inc;

    i2c_dsp_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_dsp_ptr #(.AW(AW), .ARR_PAGE(ARR_PAGE), .CTL_PAGE(CTL_PAGE)) u_ptr (
        .clk(clk), .rst_n(rst_n), .set_space(set_space), .space_in(code_space),
        .ld_hi(ld_hi), .ld_lo(ld_lo), .inc(inc), .byte_in(shreg),
        .ptr(mem_addr), .space(mem_space)
    );

    // device byte decode and random-read code match
    always_comb begin
        byte_done  = scl_fall && (bitcnt == 4'd8);
        code_hit   = (shreg[7:1] == ARRAY_CODE) || (shreg[7:1] == CTRL_CODE);
        code_space = (shreg[7:1] == CTRL_CODE);
        dev_ok     = code_hit && (!shreg[0] || !dummy_pend || (code_space == dummy_space));
    end

    // next state and pointer controls
    always_comb begin
        nxt       = state;
        set_space = 1'b0;
        ld_hi     = 1'b0;
        ld_lo     = 1'b0;
        inc       = 1'b0;
        wr_en     = 1'b0;
        wr_commit = 1'b0;
        if (state == S_BUSY) begin
            if (busy_cnt == '0) nxt = S_IDLE;
        end else if (start_det) begin
            nxt = S_DEV;
        end else if (stop_det) begin
            nxt       = wrote ? S_BUSY : S_IDLE;
            wr_commit = wrote;
        end else begin
            unique case (state)
                S_DEV: if (byte_done) begin
                    nxt       = dev_ok ? S_DEV_ACK : S_IDLE;
                    set_space = dev_ok;
                end
                S_DEV_ACK:  if (scl_fall) nxt = rw_flag ? S_RDAT : S_AHI;
                S_AHI:      if (byte_done) begin ld_hi = 1'b1; nxt = S_AHI_ACK; end
                S_AHI_ACK:  if (scl_fall) nxt = S_ALO;
                S_ALO:      if (byte_done) begin ld_lo = 1'b1; nxt = S_ALO_ACK; end
                S_ALO_ACK:  if (scl_fall) nxt = S_WDAT;
                S_WDAT:     if (byte_done) begin wr_en = 1'b1; inc = 1'b1; nxt = S_WDAT_ACK; end
                S_WDAT_ACK: if (scl_fall) nxt = S_WDAT;
                S_RDAT:     if (byte_done) begin inc = 1'b1; nxt = S_RACK; end
                S_RACK:     if (scl_fall) nxt = m_ack ? S_RDAT : S_IDLE;
                default:    nxt = state;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            bitcnt      <= '0;
            shreg       <= '0;
            rw_flag     <= 1'b0;
            wrote       <= 1'b0;
            dummy_pend  <= 1'b0;
            dummy_space <= 1'b0;
            m_ack       <= 1'b0;
            busy_cnt    <= '0;
        end else begin
            state <= nxt;
            if (start_det || nxt != state) bitcnt <= '0;
            else if (scl_rise && bitcnt != 4'd8) bitcnt <= bitcnt + 4'd1;

            if (nxt == S_RDAT && state != S_RDAT) shreg <= mem_rdata;
            else if (state == S_RDAT && scl_fall) shreg <= {shreg[6:0], 1'b0};
            else if (scl_rise && (state == S_DEV || state == S_AHI ||
                                  state == S_ALO || state == S_WDAT))
                shreg <= {shreg[6:0], sda_s};

            if (set_space) rw_flag <= shreg[0];
            if (state == S_RACK && scl_rise) m_ack <= ~sda_s;

            if (wr_en) wrote <= 1'b1;
            else if (stop_det && state != S_BUSY) wrote <= 1'b0;

            if (ld_lo) begin
                dummy_pend  <= 1'b1;
                dummy_space <= mem_space;
            end else if (set_space || wr_en || (stop_det && state != S_BUSY)) begin
                dummy_pend  <= 1'b0;
            end

            if (nxt == S_BUSY && state != S_BUSY) busy_cnt <= BW'(BUSY_CYCLES - 1);
            else if (state == S_BUSY && busy_cnt != '0) busy_cnt <= busy_cnt - BW'(1);
        end
    end

    // outputs
    always_comb begin
        wr_data = shreg;
        unique case (state)
            S_DEV_ACK, S_AHI_ACK, S_ALO_ACK, S_WDAT_ACK: sda_oe = 1'b1;
            S_RDAT:                                      sda_oe = ~shreg[7];
            default:                                     sda_oe = 1'b0;
        endcase
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !sda_oe); // R1
    AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> sda_oe); // R3
    AST_COMMIT_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> (state == S_BUSY)); // R7
    AST_BUSY_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BUSY) |-> (!sda_oe && !wr_en)); // R8
    AST_NACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RACK && scl_fall && !m_ack && !start_det && !stop_det) |=> !sda_oe); // R9

endmodule

// File: tb/i2c_dual_space_port_tb.sv
module i2c_dual_space_port_tb;
    localparam int AW   = 9;
    localparam int BUSY = 600;
    localparam int Q    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe, mem_space, wr_en, wr_commit;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata, wr_data;
    wire sda_bus = ~(m_low | sda_oe);

    int n_chk = 0, n_fail = 0, n_log = 0, n_commit = 0;
    logic [AW-1:0] log_addr [0:31];
    logic [7:0]    log_data [0:31];
    logic          log_space[0:31];
    logic          done = 1'b0;

    always #2 clk = ~clk;

    i2c_dual_space_port #(.AW(AW), .BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .mem_space(mem_space), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .wr_en(wr_en), .wr_data(wr_data), .wr_commit(wr_commit)
    );

    function automatic logic [7:0] model_rd(input logic sp, input logic [AW-1:0] a);
        return a[7:0] ^ (sp ? 8'hC3 : 8'h3C) ^ {a[8], 7'b0};
    endfunction
    assign mem_rdata = model_rd(mem_space, mem_addr);

    always @(posedge clk) begin
        if (wr_en && n_log < 32) begin
            log_addr[n_log]  <= mem_addr;
            log_data[n_log]  <= wr_data;
            log_space[n_log] <= mem_space;
            n_log <= n_log + 1;
        end
        if (wr_commit) n_commit <= n_commit + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq(); repeat (Q) @(posedge clk); #1; endtask
    task automatic bus_start(); m_low = 0; wq(); m_scl = 1; wq(); m_low = 1; wq(); m_scl = 0; wq(); endtask
    task automatic bus_stop(); m_low = 1; wq(); m_scl = 1; wq(); m_low = 0; wq(); endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; wq(); m_scl = 1; wq(); wq(); m_scl = 0; wq();
        end
        m_low = 0; wq(); m_scl = 1; wq(); ack = ~sda_bus; wq(); m_scl = 0; wq();
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        m_low = 0;
        for (int i = 7; i >= 0; i--) begin
            wq(); m_scl = 1; wq(); b[i] = sda_bus; wq(); m_scl = 0;
        end
        wq(); m_low = mack; wq(); m_scl = 1; wq(); wq(); m_scl = 0; wq(); m_low = 0;
    endtask

    // R5 R9: current-address read right after reset starts at array location 0
    task automatic t_current_read();
        logic a; logic [7:0] d;
        bus_start(); send_byte(8'hAF, a);
        chk("R1 array read code acked", a, 1);
        recv_byte(1'b1, d); chk("R5 first byte from array 0", d, model_rd(0, 0));
        recv_byte(1'b0, d); chk("R9 ack continues at next location", d, model_rd(0, 1));
        chk("R9 nack releases sda", sda_oe, 0);
        bus_stop();
        chk("R7 no commit after read", n_commit, 0);
    endtask

    // R2 R3 R4 R7: array page write crossing the page end, high byte 0xFF gives A8=1 only
    task automatic t_array_write();
        logic a; int base = n_log;
        bus_start(); send_byte(8'hAE, a); chk("R1 array write code acked", a, 1);
        send_byte(8'hFF, a); chk("R2 high address acked", a, 1);
        send_byte(8'h0E, a); chk("R2 low address acked", a, 1);
        send_byte(8'h11, a); chk("R3 data acked", a, 1);
        send_byte(8'h22, a); send_byte(8'h33, a);
        bus_stop();
        chk("R3 strobe count", n_log - base, 3);
        chk("R2 address from A8 and low byte", log_addr[base], 9'h10E);
        chk("R3 data byte", log_data[base], 8'h11);
        chk("R3 array space", log_space[base], 0);
        chk("R4 array step", log_addr[base+1], 9'h10F);
        chk("R4 array wrap to page start", log_addr[base+2], 9'h100);
        chk("R3 wrapped data", log_data[base+2], 8'h33);
        chk("R7 one commit", n_commit, 1);
        repeat (BUSY + 200) @(posedge clk); #1;
    endtask

    // R4 R8: control page wrap at 8, then deaf interval after its commit
    task automatic t_ctrl_write_busy();
        logic a; int base = n_log; int c0 = n_commit;
        bus_start(); send_byte(8'hDE, a); chk("R1 control write code acked", a, 1);
        send_byte(8'h00, a); send_byte(8'h06, a);
        send_byte(8'hA1, a); send_byte(8'hA2, a); send_byte(8'hA3, a);
        bus_stop();
        chk("R1 control space", log_space[base], 1);
        chk("R4 control step", log_addr[base+1], 9'h007);
        chk("R4 control wrap to page start", log_addr[base+2], 9'h000);
        chk("R7 commit after control write", n_commit - c0, 1);
        bus_start(); send_byte(8'hAE, a);
        chk("R8 nack while busy", a, 0);
        bus_stop();
        repeat (BUSY + 200) @(posedge clk); #1;
        bus_start(); send_byte(8'hAE, a);
        chk("R8 ack after busy interval", a, 1);
        bus_stop();
        chk("R7 no commit without data", n_commit - c0, 1);
    endtask

    // R6 R9: random read with matching code, MSB-first data
    task automatic t_random_read();
        logic a; logic [7:0] d;
        bus_start(); send_byte(8'hAE, a); send_byte(8'h01, a); send_byte(8'h25, a);
        bus_start(); send_byte(8'hAF, a);
        chk("R6 matching read code acked", a, 1);
        recv_byte(1'b1, d); chk("R9 random read byte", d, model_rd(0, 9'h125));
        recv_byte(1'b0, d); chk("R9 next random byte", d, model_rd(0, 9'h126));
        bus_stop();
        chk("R7 no commit after random read", n_commit, 2);
    endtask

    // R6: foreign code in the read phase
    task automatic t_read_mismatch();
        logic a;
        bus_start(); send_byte(8'hAE, a); send_byte(8'h00, a); send_byte(8'h40, a);
        bus_start(); send_byte(8'hDF, a);
        chk("R6 mismatched read code nacked", a, 0);
        bus_stop();
    endtask

    // R1: unknown code nacked and later bytes ignored until START
    task automatic t_bad_code();
        logic a; int base = n_log;
        bus_start(); send_byte(8'h90, a);
        chk("R1 unknown code nacked", a, 0);
        send_byte(8'hAE, a);
        chk("R1 ignored until start", a, 0);
        bus_stop();
        chk("R1 no strobe while ignoring", n_log - base, 0);
    endtask

    initial begin
        repeat (5) @(posedge clk); #1;
        chk("R5 reset sda released", sda_oe, 0);
        chk("R5 reset no write", wr_en, 0);
        rst_n = 1'b1;
        repeat (5) @(posedge clk); #1;
        chk("R5 reset pointer", mem_addr, 0);
        t_current_read();
        t_array_write();
        t_ctrl_write_busy();
        t_random_read();
        t_read_mismatch();
        t_bad_code();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule